// File: doc/BRIEF.md
# Subranging Conversion Timing Sequencer

This block is the clocked controller behind a four-step subranging converter. A single rising edge on an asynchronous encode input starts a conversion. The block then produces four one-cycle flash strobes, separated by settling gaps for the residue amplifier. After the last strobe it produces a one-cycle result-latch enable, and finally a data-available (DAV) pulse. The latch enable fires while DAV is low and a fixed number of cycles before DAV rises. Captured data therefore holds steady across the whole DAV pulse, and a downstream register can capture on either DAV edge.

Two timing sets are chosen by parameter: a fast grade and a slow grade. Each set holds the cycle counts for the lead-in, the three strobe gaps, the strobe-to-latch delay, the latch-to-DAV setup and the DAV width. The grade input is sampled once when a conversion starts. Encode edges that arrive during a conversion are discarded and raise a sticky error flag.

Top module: `conv_timing_seq`

## Requirements
- R1: While reset is asserted and right after it is released, all strobes, the latch enable, DAV, busy and the error flag are low.
- R2: The first strobe (`strobe_o[0]`) rises exactly NSYNC + lead clock cycles after the first rising clock edge at which `enc_i` is sampled high following a low period. With defaults, NSYNC=2 and lead is 2 (fast) or 4 (slow).
- R3: Each conversion produces exactly four strobes in the order `strobe_o[0]`, `[1]`, `[2]`, `[3]`. Each strobe is one cycle wide, at most one bit is high at a time, and no strobe fires while busy is low. Consecutive strobes are spaced gap1/gap2/gap3 cycles: 20/20/16 fast, 30/30/24 slow.
- R4: `latch_o` pulses for one cycle, lat cycles after the fourth strobe (10 fast, 14 slow). It is never high while `dav_o` is high.
- R5: `dav_o` rises setup cycles after the latch pulse (5 fast, 6 slow), so data is stable at least 20 ns before the DAV rising edge at 200 MHz.
- R6: `dav_o` stays high for davw cycles (20 fast, 30 slow). It then falls in the same cycle as `busy_o`.
- R7: `busy_o` rises one cycle after the encode edge is detected (NSYNC cycles after the first sampling edge) and stays high until DAV falls. An encode edge arriving right after busy falls starts a new conversion.
- R8: A rising encode edge while busy has no effect on strobes, latch or DAV. It sets `err_o`, which stays high until reset.
- R9: `slow_i` is sampled when a conversion starts. Changing it mid-conversion does not alter that conversion's timing.
- R10: Holding `enc_i` high for longer than a conversion yields exactly one conversion and does not set `err_o`.
- R11: At a 5 ns clock the default counts keep the DAV rise within 500 ns (fast) or 750 ns (slow) of the encode rise. The third strobe comes at least 200 ns after the encode rise. The DAV width lies within 75–200 ns (fast) or 75–300 ns (slow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_i | input | 1 | Asynchronous encode request; a rising edge starts a conversion |
| slow_i | input | 1 | Grade select: 1 selects slow timing, 0 fast |
| strobe_o | output | 4 | One-cycle flash strobes; bit k is flash step k+1 |
| latch_o | output | 1 | One-cycle result-latch enable |
| dav_o | output | 1 | Data-available pulse |
| busy_o | output | 1 | Conversion in progress |
| err_o | output | 1 | Sticky flag for an encode edge received while busy |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and the fast and slow timing sets listed in R2–R6, on a 200 MHz clock. At that frequency every interval maps directly to nanoseconds, so the grade limits in R11 can be checked against measured cycle counts. The slow set is long enough for a mid-conversion grade change and an overrun pulse to land well inside a conversion. Overrun, held encode and back-to-back starts each get their own scenario.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int CW      = 8;
  localparam int FLASH_N = 4;
  localparam int IW      = $clog2(FLASH_N);

  typedef struct packed {
    logic [CW-1:0] lead;
    logic [CW-1:0] gap1;
    logic [CW-1:0] gap2;
    logic [CW-1:0] gap3;
    logic [CW-1:0] lat;
    logic [CW-1:0] setup;
    logic [CW-1:0] davw;
  } tim_t;

  localparam tim_t FAST_DEF = '{lead: 8'd2, gap1: 8'd20, gap2: 8'd20, gap3: 8'd16,
                                lat: 8'd10, setup: 8'd5, davw: 8'd20};
  localparam tim_t SLOW_DEF = '{lead: 8'd4, gap1: 8'd30, gap2: 8'd30, gap3: 8'd24,
                                lat: 8'd14, setup: 8'd6, davw: 8'd30};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLASH,
    ST_LATCH,
    ST_SETUP,
    ST_DAV
  } st_e;
endpackage

// File: rtl/conv_enc_sync.sv
module conv_enc_sync #(
  parameter int NSYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enc_i,
  output logic rise_o
);
  logic [NSYNC-1:0] sh_q;
  logic             last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[NSYNC-2:0], enc_i};
      last_q <= sh_q[NSYNC-1];
    end
  end

  assign rise_o = sh_q[NSYNC-1] & ~last_q;
endmodule

// File: rtl/conv_seq_core.sv
module conv_seq_core
  import conv_seq_pkg::*;
#(
  parameter tim_t FAST_T = FAST_DEF,
  parameter tim_t SLOW_T = SLOW_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          slow_i,
  output logic          fire_o,
  output logic [IW-1:0] idx_o,
  output logic          latch_o,
  output logic          dav_o,
  output logic          busy_o,
  output logic          err_o
);
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [IW-1:0] LAST = IW'(FLASH_N - 1);

  st_e           st_q;
  tim_t          t_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          latch_q, dav_q, err_q;
  logic          zero;
  logic [CW-1:0] gap_sel;
  tim_t          t_new;

  assign zero  = (cnt_q == '0);
  assign t_new = slow_i ? SLOW_T : FAST_T;

  always_comb begin
    unique case (idx_q)
      IW'(0):  gap_sel = t_q.gap1;
      IW'(1):  gap_sel = t_q.gap2;
      default: gap_sel = t_q.gap3;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      t_q     <= FAST_T;
      cnt_q   <= '0;
      idx_q   <= '0;
      latch_q <= 1'b0;
      dav_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      latch_q <= 1'b0;
      if (start_i && st_q != ST_IDLE) err_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          t_q   <= t_new;
          cnt_q <= t_new.lead - ONE;
          idx_q <= '0;
          st_q  <= ST_FLASH;
        end
        ST_FLASH: if (zero) begin
          if (idx_q == LAST) begin
            cnt_q <= t_q.lat - ONE;
            st_q  <= ST_LATCH;
          end else begin
            cnt_q <= gap_sel - ONE;
            idx_q <= idx_q + 1'b1;
          end
        end else cnt_q <= cnt_q - ONE;
        ST_LATCH: if (zero) begin
          latch_q <= 1'b1;
          cnt_q   <= t_q.setup - ONE;
          st_q    <= ST_SETUP;
        end else cnt_q <= cnt_q - ONE;
        ST_SETUP: if (zero) begin
          dav_q <= 1'b1;
          cnt_q <= t_q.davw - ONE;
          st_q  <= ST_DAV;
        end else cnt_q <= cnt_q - ONE;
        ST_DAV: if (zero) begin
          dav_q <= 1'b0;
          st_q  <= ST_IDLE;
        end else cnt_q <= cnt_q - ONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fire_o  = (st_q == ST_FLASH) && zero;
  assign idx_o   = idx_q;
  assign latch_o = latch_q;
  assign dav_o   = dav_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign err_o   = err_q;
endmodule

// File: rtl/conv_strobe_gen.sv
module conv_strobe_gen
  import conv_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [IW-1:0]      idx_i,
  output logic [FLASH_N-1:0] strobe_o
);
  for (genvar k = 0; k < FLASH_N; k++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_o[k] <= 1'b0;
      else         strobe_o[k] <= fire_i && (idx_i == IW'(k));
    end
  end
endmodule

// File: rtl/conv_timing_seq.sv
module conv_timing_seq
  import conv_seq_pkg::*;
#(
  parameter int   NSYNC  = 2,
  parameter tim_t FAST_T = FAST_DEF,
  parameter tim_t SLOW_T = SLOW_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enc_i,
  input  logic               slow_i,
  output logic [FLASH_N-1:0] strobe_o,
  output logic               latch_o,
  output logic               dav_o,
  output logic               busy_o,
  output logic               err_o
);
  logic          start;
  logic          fire;
  logic [IW-1:0] idx;

  conv_enc_sync #(.NSYNC(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .enc_i (enc_i),
    .rise_o(start)
  );

  conv_seq_core #(.FAST_T(FAST_T), .SLOW_T(SLOW_T)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .slow_i (slow_i),
    .fire_o (fire),
    .idx_o  (idx),
    .latch_o(latch_o),
    .dav_o  (dav_o),
    .busy_o (busy_o),
    .err_o  (err_o)
  );

  conv_strobe_gen u_stb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .idx_i   (idx),
    .strobe_o(strobe_o)
  );
endmodule

// File: rtl/conv_timing_seq_chk.sv
module conv_timing_seq_chk
  import conv_seq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [FLASH_N-1:0] strobe_o,
  input logic               latch_o,
  input logic               dav_o,
  input logic               busy_o,
  input logic               err_o
);
  // R3
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));
  // R3
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> busy_o);
  // R3
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |=> (strobe_o == '0));
  // R4
  latch_dav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !dav_o);
  // R4
  latch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
  // R6
  dav_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dav_o) |-> !busy_o);
  // R7
  dav_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dav_o |-> busy_o);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind conv_timing_seq conv_timing_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strobe_o(strobe_o),
  .latch_o (latch_o),
  .dav_o   (dav_o),
  .busy_o  (busy_o),
  .err_o   (err_o)
);

// File: tb/tb_conv_timing_seq.sv
`timescale 1ns/1ps
module tb_conv_timing_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enc_i = 1'b0;
  logic       slow_i = 1'b0;
  logic [3:0] strobe_o;
  logic       latch_o, dav_o, busy_o, err_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // expected timing per grade: lead, gap1, gap2, gap3, lat, setup, davw
  int tf[7] = '{2, 20, 20, 16, 10, 5, 20};
  int ts[7] = '{4, 30, 30, 24, 14, 6, 30};
  localparam int NSY = 2;

  int n_str[4], t_str[4];
  int n_lat, t_lat, n_dr, t_dr, n_df, t_df, n_br, t_br, n_bf, t_bf;
  logic dav_p = 1'b0, busy_p = 1'b0;

  conv_timing_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enc_i(enc_i), .slow_i(slow_i),
    .strobe_o(strobe_o), .latch_o(latch_o), .dav_o(dav_o),
    .busy_o(busy_o), .err_o(err_o)
  );

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  always @(negedge clk_i) begin
    for (int k = 0; k < 4; k++) if (strobe_o[k]) begin n_str[k]++; t_str[k] = cyc; end
    if (latch_o) begin n_lat++; t_lat = cyc; end
    if (dav_o && !dav_p) begin n_dr++; t_dr = cyc; end
    if (!dav_o && dav_p) begin n_df++; t_df = cyc; end
    if (busy_o && !busy_p) begin n_br++; t_br = cyc; end
    if (!busy_o && busy_p) begin n_bf++; t_bf = cyc; end
    dav_p  = dav_o;
    busy_p = busy_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int k = 0; k < 4; k++) begin n_str[k] = 0; t_str[k] = 0; end
    n_lat = 0; n_dr = 0; n_df = 0; n_br = 0; n_bf = 0;
  endtask

  function automatic int tv(input bit slow, input int i);
    return slow ? ts[i] : tf[i];
  endfunction

  task automatic run_conv(input bit slow, input int hold, input int swap_at,
                          input int rogue_at, input bit exp_err);
    int c0 = 0;
    int e;
    bit done = 0;
    real dt;
    clear_log();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      if (i == 0) c0 = cyc;
      enc_i  = (i < hold) || (rogue_at > 0 && i >= rogue_at && i < rogue_at + 5);
      slow_i = (swap_at > 0 && i >= swap_at) ? ~slow : slow;
      if (n_df >= 1 && i > hold + 3 && (rogue_at == 0 || i > rogue_at + 8)) begin
        done = 1;
        break;
      end
    end
    enc_i = 1'b0;
    chk(done, "R6 conversion completes", int'(done), 1);
    // R2: first strobe after sync plus lead
    e = c0 + 1 + NSY + tv(slow, 0);
    chk(t_str[0] == e, "R2 first strobe time", t_str[0], e);
    // R3: spacing and count
    for (int k = 1; k < 4; k++) begin
      e = t_str[k-1] + tv(slow, k);
      chk(t_str[k] == e, "R3 strobe spacing", t_str[k], e);
    end
    for (int k = 0; k < 4; k++) chk(n_str[k] == 1, "R3 strobe count", n_str[k], 1);
    // R4
    e = t_str[3] + tv(slow, 4);
    chk(t_lat == e && n_lat == 1, "R4 latch timing", t_lat, e);
    // R5
    e = t_lat + tv(slow, 5);
    chk(t_dr == e && n_dr == 1, "R5 dav rise", t_dr, e);
    // R6
    e = t_dr + tv(slow, 6);
    chk(t_df == e, "R6 dav fall", t_df, e);
    chk(t_bf == t_df && n_bf == 1, "R6 busy falls with dav", t_bf, t_df);
    // R7
    e = c0 + 1 + NSY;
    chk(t_br == e && n_br == 1, "R7 busy rise", t_br, e);
    // R8 / R10
    chk(err_o == exp_err, "R8 R10 error flag", int'(err_o), int'(exp_err));
    // R11 limits in ns
    dt = (t_dr - c0) * 5.0 - 2.5;
    chk(dt <= (slow ? 750.0 : 500.0), "R11 conversion time", int'(dt), slow ? 750 : 500);
    dt = (t_str[2] - c0) * 5.0 - 2.5;
    chk(dt >= 200.0, "R11 third strobe settle", int'(dt), 200);
    e = (t_df - t_dr) * 5;
    chk(e >= 75 && e <= (slow ? 300 : 200), "R11 dav width", e, 75);
    e = (t_dr - t_lat) * 5;
    chk(e >= 20, "R5 setup before dav", e, 20);
  endtask

  task automatic t_reset();
    chk(strobe_o == 4'b0 && latch_o == 1'b0, "R1 strobes/latch in reset",
        int'({strobe_o, latch_o}), 0);
    chk(dav_o == 1'b0 && busy_o == 1'b0 && err_o == 1'b0, "R1 dav/busy/err in reset",
        int'({dav_o, busy_o, err_o}), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(strobe_o == 4'b0 && dav_o == 1'b0 && busy_o == 1'b0 && err_o == 1'b0,
        "R1 idle after reset", int'({strobe_o, dav_o, busy_o, err_o}), 0);
  endtask

  task automatic t_fast();     run_conv(1'b0, 5, 0, 0, 1'b0); endtask
  task automatic t_slow();     run_conv(1'b1, 5, 0, 0, 1'b0); endtask
  // R10: long encode high gives one conversion
  task automatic t_held();     run_conv(1'b0, 150, 0, 0, 1'b0); endtask
  // R9: grade flips mid-conversion in both directions
  task automatic t_swap();
    run_conv(1'b0, 5, 20, 0, 1'b0);
    run_conv(1'b1, 5, 20, 0, 1'b0);
  endtask
  // R7: restart immediately after busy drops
  task automatic t_back2back();
    run_conv(1'b0, 5, 0, 0, 1'b0);
    run_conv(1'b1, 5, 0, 0, 1'b0);
  endtask
  // R8: encode edge while busy ignored, flag sticky
  task automatic t_overrun();
    run_conv(1'b0, 5, 0, 30, 1'b1);
    repeat (4) @(negedge clk_i);
    run_conv(1'b0, 5, 0, 0, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk_i);
    t_reset();
    t_fast();
    t_slow();
    t_held();
    t_swap();
    t_back2back();
    t_overrun();
    repeat (5) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule